// File: doc/BRIEF.md
# Banked Gather-Load Read Array with Conflict Side Caches

This block is the read path of a banked first-level data array that serves several gather-load lanes in the same cycle. A line address is mapped to a bank by its low bits. When two or more lanes land on the same bank, the lowest-numbered lane wins the bank port. Every other lane on that bank loses and must reissue, unless it can be served another way.

Each bank carries a very small side cache of recently lost lines, each entry holding a valid bit, an address tag and the line data. When a lane loses on a bank and its line is missing from that bank's side cache, the block captures the line into the side cache on the following cycle. If the same collision happens again, the side cache answers the losing lane. Its data is steered onto the next bank's output port, so the bank behaves like a pseudo dual-port bank, provided that neighbouring port is idle.

The array itself always hits. Writes update the array and drop any side-cache copy of the written line. Results, served flags and retry flags appear one cycle after the request.

Top module: `gather_bank_array`

## Requirements
- R1: While reset is held, and in the first cycle after it, every lane reports no result, no side-path flag and no retry, with data zero.
- R2: A lane's bank is the low log2(NUM_BANKS) bits of its line address. A request to a bank no other lane uses returns that line's data with `rsp_valid` one cycle later. A read in the same cycle as a write to the same line returns the data from before the write.
- R3: Among lanes that request one bank in a cycle, the lowest lane index wins the bank port, even when the addresses are equal. Lane 0 therefore never retries.
- R4: Every lane that requested in a cycle shows exactly one of `rsp_valid` or `rsp_retry` one cycle later. A lane that did not request shows neither.
- R5: A losing lane whose line is held in its bank's side cache is served one cycle later with `rsp_valid` and `rsp_side` high. This happens only if no lane requested bank (b+1) mod NUM_BANKS that cycle, and for at most one lane per bank: the lowest such loser. Any other loser retries.
- R6: In a conflict cycle, the lowest losing lane whose line is neither in the side cache nor already being captured has its line captured into that bank's side cache. The line can be served from the side cache starting two cycles after the conflict.
- R7: A side cache holds SIDE_ENTRIES lines (default 2) and replaces them in first-in, first-out order.
- R8: A write to a line removes any side-cache copy of it in the same cycle. A capture of that line whose fill would land in the cycle of the write is dropped. Stale data is never returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_LANES | Per-lane read request |
| req_addr | input | NUM_LANES*ADDR_W | Per-lane line address, lane l in bits [l*ADDR_W +: ADDR_W] |
| wr_en | input | 1 | Line write strobe |
| wr_addr | input | ADDR_W | Line address of the write |
| wr_data | input | DATA_W | Line data of the write |
| rsp_valid | output | NUM_LANES | Lane served this cycle (result of the previous cycle's request) |
| rsp_side | output | NUM_LANES | Lane served from a side cache through the neighbour port |
| rsp_retry | output | NUM_LANES | Lane lost arbitration and was not served; it must reissue |
| rsp_data | output | NUM_LANES*DATA_W | Per-lane line data, zero when the lane is not served |

## Verification
The assertions assume that `req_valid` and `req_addr` are driven to known values on every clock edge after reset. They also assume the bank count is a power of two, so that the neighbour of the last bank wraps to bank 0.

The stimulus changes inputs only on the falling clock edge and writes every line once before any read. As a result, each returned value is defined. Each collision is repeated after a single idle cycle, which is enough for the capture of R6 to finish before the repeat is observed.

// File: rtl/gba_pkg.sv
package gba_pkg;

   typedef enum logic [1:0] {
      RSP_NONE  = 2'd0,
      RSP_BANK  = 2'd1,
      RSP_SIDE  = 2'd2,
      RSP_RETRY = 2'd3
   } rsp_kind_e;

   function automatic int next_bank(input int b, input int n);
      return (b + 1) % n;
   endfunction

endpackage

// File: rtl/gba_lane_arbiter.sv
module gba_lane_arbiter #(
   parameter int NUM_LANES = 4
) (
   input  logic [NUM_LANES-1:0] req,
   output logic [NUM_LANES-1:0] grant,
   output logic [NUM_LANES-1:0] lose
);

   always_comb begin
      logic taken;
      taken = 1'b0;
      grant = '0;
      for (int l = 0; l < NUM_LANES; l++) begin
         if (req[l] && !taken) begin
            grant[l] = 1'b1;
            taken    = 1'b1;
         end
      end
   end

   assign lose = req & ~grant;

endmodule

// File: rtl/gba_bank_store.sv
module gba_bank_store #(
   parameter int ROW_W  = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [DATA_W-1:0] rd_data,
   input  logic [ROW_W-1:0]  peek_row,
   output logic [DATA_W-1:0] peek_data
);

   localparam int ROWS = 1 << ROW_W;

   logic [DATA_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_row] <= wr_data;
      if (rd_en) rd_data <= mem[rd_row];
   end

   assign peek_data = mem[peek_row];

endmodule

// File: rtl/gba_side_cache.sv
module gba_side_cache #(
   parameter int NUM_LANES = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int ENTRIES   = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LANES-1:0]        lose,
   input  logic [NUM_LANES*ADDR_W-1:0] lane_addr_flat,
   input  logic                        nbr_free,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]           fill_data,
   output logic [ADDR_W-1:0]           fill_addr,
   output logic [NUM_LANES-1:0]        serve,
   output logic [DATA_W-1:0]           serve_data
);

   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [ENTRIES-1:0] ent_vld;
   logic [ADDR_W-1:0]  ent_tag  [ENTRIES];
   logic [DATA_W-1:0]  ent_data [ENTRIES];
   logic [PTR_W-1:0]   ptr;
   logic               cap_vld;
   logic [ADDR_W-1:0]  cap_addr;

   logic [NUM_LANES-1:0] lane_hit;
   logic [DATA_W-1:0]    lane_data [NUM_LANES];
   logic                 cand_vld;
   logic [ADDR_W-1:0]    cand_addr;
   logic                 fill_go;

   // tag match per lane against the stored entries
   always_comb begin
      for (int l = 0; l < NUM_LANES; l++) begin
         lane_hit[l]  = 1'b0;
         lane_data[l] = '0;
         for (int e = 0; e < ENTRIES; e++) begin
            if (ent_vld[e] && ent_tag[e] == lane_addr_flat[l*ADDR_W +: ADDR_W]) begin
               lane_hit[l]  = 1'b1;
               lane_data[l] = ent_data[e];
            end
         end
      end
   end

   // pick the served loser and the capture candidate
   always_comb begin
      logic [ADDR_W-1:0] a;
      serve      = '0;
      serve_data = '0;
      cand_vld   = 1'b0;
      cand_addr  = '0;
      for (int l = 0; l < NUM_LANES; l++) begin
         a = lane_addr_flat[l*ADDR_W +: ADDR_W];
         if (lose[l]) begin
            if (lane_hit[l]) begin
               if (nbr_free && serve == '0) begin
                  serve[l]   = 1'b1;
                  serve_data = lane_data[l];
               end
            end else if (!(cap_vld && cap_addr == a) && !cand_vld) begin
               cand_vld  = 1'b1;
               cand_addr = a;
            end
         end
      end
   end

   assign fill_addr = cap_addr;
   assign fill_go   = cap_vld && !(wr_en && wr_addr == cap_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld  <= '0;
         ptr      <= '0;
         cap_vld  <= 1'b0;
         cap_addr <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            ent_tag[e]  <= '0;
            ent_data[e] <= '0;
         end
      end else begin
         cap_vld  <= cand_vld;
         cap_addr <= cand_addr;
         for (int e = 0; e < ENTRIES; e++) begin
            if (wr_en && ent_vld[e] && ent_tag[e] == wr_addr) ent_vld[e] <= 1'b0;
         end
         if (fill_go) begin
            ent_vld[ptr]  <= 1'b1;
            ent_tag[ptr]  <= cap_addr;
            ent_data[ptr] <= fill_data;
            ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/gather_bank_array.sv
module gather_bank_array
   import gba_pkg::*;
#(
   parameter int NUM_LANES    = 4,
   parameter int NUM_BANKS    = 4,
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int SIDE_ENTRIES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LANES-1:0]        req_valid,
   input  logic [NUM_LANES*ADDR_W-1:0] req_addr,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [NUM_LANES-1:0]        rsp_valid,
   output logic [NUM_LANES-1:0]        rsp_side,
   output logic [NUM_LANES-1:0]        rsp_retry,
   output logic [NUM_LANES*DATA_W-1:0] rsp_data
);

   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int ROW_W  = ADDR_W - BANK_W;

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (ADDR_W <= BANK_W) begin : g_bad_addr
      $error("ADDR_W must exceed the bank index width");
   end
   if (NUM_LANES < 2) begin : g_bad_lanes
      $error("NUM_LANES must be at least 2");
   end
   if (SIDE_ENTRIES < 1) begin : g_bad_side
      $error("SIDE_ENTRIES must be at least 1");
   end

   logic [ADDR_W-1:0]    lane_addr [NUM_LANES];
   logic [BANK_W-1:0]    lane_bank [NUM_LANES];
   logic [NUM_LANES-1:0] bank_req   [NUM_BANKS];
   logic [NUM_LANES-1:0] bank_grant [NUM_BANKS];
   logic [NUM_LANES-1:0] bank_lose  [NUM_BANKS];
   logic [NUM_LANES-1:0] bank_serve [NUM_BANKS];
   logic [DATA_W-1:0]    bank_rd    [NUM_BANKS];
   logic [DATA_W-1:0]    side_data  [NUM_BANKS];

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_addr
      assign lane_addr[l] = req_addr[l*ADDR_W +: ADDR_W];
      assign lane_bank[l] = lane_addr[l][BANK_W-1:0];
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int NBR = next_bank(b, NUM_BANKS);

      logic [NUM_LANES-1:0] req;
      logic [NUM_LANES-1:0] grant;
      logic [NUM_LANES-1:0] lose;
      logic [NUM_LANES-1:0] serve;
      logic [ROW_W-1:0]     win_row;
      logic [ADDR_W-1:0]    fill_addr;
      logic [DATA_W-1:0]    fill_data;
      logic [DATA_W-1:0]    rd_data;
      logic [DATA_W-1:0]    sdata;
      logic                 nbr_free;

      for (genvar l = 0; l < NUM_LANES; l++) begin : g_req
         assign req[l] = req_valid[l] && (lane_bank[l] == BANK_W'(b));
      end

      assign bank_req[b] = req;
      assign nbr_free    = ~|bank_req[NBR];

      gba_lane_arbiter #(.NUM_LANES(NUM_LANES)) arb_i (
         .req   (req),
         .grant (grant),
         .lose  (lose)
      );

      always_comb begin
         win_row = '0;
         for (int l = NUM_LANES - 1; l >= 0; l--) begin
            if (grant[l]) win_row = lane_addr[l][ADDR_W-1:BANK_W];
         end
      end

      gba_bank_store #(.ROW_W(ROW_W), .DATA_W(DATA_W)) store_i (
         .clk       (clk),
         .wr_en     (wr_en && (wr_addr[BANK_W-1:0] == BANK_W'(b))),
         .wr_row    (wr_addr[ADDR_W-1:BANK_W]),
         .wr_data   (wr_data),
         .rd_en     (|grant),
         .rd_row    (win_row),
         .rd_data   (rd_data),
         .peek_row  (fill_addr[ADDR_W-1:BANK_W]),
         .peek_data (fill_data)
      );

      gba_side_cache #(
         .NUM_LANES (NUM_LANES),
         .ADDR_W    (ADDR_W),
         .DATA_W    (DATA_W),
         .ENTRIES   (SIDE_ENTRIES)
      ) side_i (
         .clk            (clk),
         .rst_n          (rst_n),
         .lose           (lose),
         .lane_addr_flat (req_addr),
         .nbr_free       (nbr_free),
         .wr_en          (wr_en),
         .wr_addr        (wr_addr),
         .fill_data      (fill_data),
         .fill_addr      (fill_addr),
         .serve          (serve),
         .serve_data     (sdata)
      );

      assign bank_grant[b] = grant;
      assign bank_lose[b]  = lose;
      assign bank_serve[b] = serve;
      assign bank_rd[b]    = rd_data;
      assign side_data[b]  = sdata;
   end

   rsp_kind_e         kind_d  [NUM_LANES];
   rsp_kind_e         kind_q  [NUM_LANES];
   logic [DATA_W-1:0] spick_d [NUM_LANES];
   logic [DATA_W-1:0] sdata_q [NUM_LANES];
   logic [BANK_W-1:0] bank_q  [NUM_LANES];

   always_comb begin
      for (int l = 0; l < NUM_LANES; l++) begin
         kind_d[l]  = RSP_NONE;
         spick_d[l] = side_data[lane_bank[l]];
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_grant[b][l])      kind_d[l] = RSP_BANK;
            else if (bank_serve[b][l]) kind_d[l] = RSP_SIDE;
            else if (bank_lose[b][l])  kind_d[l] = RSP_RETRY;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < NUM_LANES; l++) begin
            kind_q[l]  <= RSP_NONE;
            sdata_q[l] <= '0;
            bank_q[l]  <= '0;
         end
      end else begin
         for (int l = 0; l < NUM_LANES; l++) begin
            kind_q[l]  <= kind_d[l];
            sdata_q[l] <= spick_d[l];
            bank_q[l]  <= lane_bank[l];
         end
      end
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_out
      assign rsp_valid[l] = (kind_q[l] == RSP_BANK) || (kind_q[l] == RSP_SIDE);
      assign rsp_side[l]  = (kind_q[l] == RSP_SIDE);
      assign rsp_retry[l] = (kind_q[l] == RSP_RETRY);
      assign rsp_data[l*DATA_W +: DATA_W] =
         (kind_q[l] == RSP_BANK) ? bank_rd[bank_q[l]] :
         (kind_q[l] == RSP_SIDE) ? sdata_q[l] : '0;
   end

endmodule

// File: rtl/gba_checker.sv
module gba_checker #(
   parameter int NUM_LANES = 4,
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_LANES-1:0]        req_valid,
   input logic [NUM_LANES*ADDR_W-1:0] req_addr,
   input logic [NUM_LANES-1:0]        rsp_valid,
   input logic [NUM_LANES-1:0]        rsp_side,
   input logic [NUM_LANES-1:0]        rsp_retry
);

   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   logic                 started;
   logic [NUM_LANES-1:0] conf_d, conf_q;
   logic [NUM_LANES-1:0] busy_d, busy_q;

   always_comb begin
      logic [BANK_W-1:0] bl;
      logic [BANK_W-1:0] bk;
      for (int l = 0; l < NUM_LANES; l++) begin
         conf_d[l] = 1'b0;
         busy_d[l] = 1'b0;
         bl = req_addr[l*ADDR_W +: BANK_W];
         for (int k = 0; k < NUM_LANES; k++) begin
            bk = req_addr[k*ADDR_W +: BANK_W];
            if (k < l && req_valid[k] && req_valid[l] && bk == bl) conf_d[l] = 1'b1;
            if (req_valid[k] && bk == BANK_W'(bl + 1'b1)) busy_d[l] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         conf_q  <= '0;
         busy_q  <= '0;
      end else begin
         started <= 1'b1;
         conf_q  <= conf_d;
         busy_q  <= busy_d;
      end
   end

   // R4
   served_or_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid & rsp_retry) == '0);

   // R4
   every_request_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> ((rsp_valid | rsp_retry) == $past(req_valid)));

   // R3
   lane_zero_never_retries_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_retry[0] == 1'b0);

   // R5
   side_implies_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_side & ~rsp_valid) == '0);

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      // R5
      side_only_for_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_side[l] |-> (conf_q[l] && !busy_q[l]));
   end

endmodule

bind gather_bank_array gba_checker #(
   .NUM_LANES (NUM_LANES),
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .rsp_side  (rsp_side),
   .rsp_retry (rsp_retry)
);

// File: tb/gather_bank_array_tb_top.sv
module gather_bank_array_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 4;
   localparam int AW = 8;
   localparam int DW = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NL-1:0]  req_valid = '0;
   logic [NL*AW-1:0] req_addr = '0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  wr_addr = '0;
   logic [DW-1:0]  wr_data = '0;
   logic [NL-1:0]  rsp_valid, rsp_side, rsp_retry;
   logic [NL*DW-1:0] rsp_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] mdl [256];

   logic [NL-1:0]    q_v[$];
   logic [NL-1:0]    q_s[$];
   logic [NL-1:0]    q_r[$];
   logic [NL*DW-1:0] q_d[$];
   string            q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   gather_bank_array dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rsp_valid (rsp_valid),
      .rsp_side  (rsp_side),
      .rsp_retry (rsp_retry),
      .rsp_data  (rsp_data)
   );

   function automatic logic [DW-1:0] seed_val(input logic [AW-1:0] a);
      return {a, ~a, a ^ 8'h5A, 8'hC3};
   endfunction

   // driver: one request cycle, expected outcome pushed to the scoreboard
   task automatic drive(input logic [NL-1:0] v, input logic [NL*AW-1:0] addrs,
                        input logic [NL-1:0] es, input logic [NL-1:0] er,
                        input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input string tag);
      logic [NL-1:0]    ev;
      logic [NL*DW-1:0] ed;
      @(negedge clk);
      req_valid = v;
      req_addr  = addrs;
      wr_en     = we;
      wr_addr   = wa;
      wr_data   = wd;
      ev = v & ~er;
      ed = '0;
      for (int l = 0; l < NL; l++) begin
         if (ev[l]) ed[l*DW +: DW] = mdl[addrs[l*AW +: AW]];
      end
      q_v.push_back(ev);
      q_s.push_back(es);
      q_r.push_back(er);
      q_d.push_back(ed);
      q_tag.push_back(tag);
      if (we) mdl[wa] = wd;
   endtask

   task automatic rd(input logic [NL-1:0] v, input logic [AW-1:0] a3, input logic [AW-1:0] a2,
                     input logic [AW-1:0] a1, input logic [AW-1:0] a0,
                     input logic [NL-1:0] es, input logic [NL-1:0] er, input string tag);
      drive(v, {a3, a2, a1, a0}, es, er, 1'b0, '0, '0, tag);
   endtask

   task automatic idle(input string tag);
      drive('0, '0, '0, '0, 1'b0, '0, '0, tag);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      drive('0, '0, '0, '0, 1'b1, a, d, tag);
   endtask

   // monitor: compare outputs shortly after each rising edge
   always @(posedge clk) begin
      #2;
      if (q_v.size() > 0) begin
         logic [NL-1:0]    ev, es, er;
         logic [NL*DW-1:0] ed;
         string            tg;
         ev = q_v.pop_front();
         es = q_s.pop_front();
         er = q_r.pop_front();
         ed = q_d.pop_front();
         tg = q_tag.pop_front();
         for (int l = 0; l < NL; l++) begin
            checks++;
            if (rsp_valid[l] !== ev[l] || rsp_side[l] !== es[l] || rsp_retry[l] !== er[l] ||
                rsp_data[l*DW +: DW] !== ed[l*DW +: DW]) begin
               errors++;
               $display("FAIL %s lane %0d: got v=%b s=%b r=%b d=%h, expected v=%b s=%b r=%b d=%h",
                        tg, l, rsp_valid[l], rsp_side[l], rsp_retry[l], rsp_data[l*DW +: DW],
                        ev[l], es[l], er[l], ed[l*DW +: DW]);
            end
         end
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, got hang, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 256; a++) mdl[a] = 'x;
      repeat (3) @(negedge clk);
      // R1: quiet outputs under reset
      checks++;
      if (rsp_valid !== '0 || rsp_side !== '0 || rsp_retry !== '0 || rsp_data !== '0) begin
         errors++;
         $display("FAIL R1 reset: got v=%b s=%b r=%b d=%h, expected all zero",
                  rsp_valid, rsp_side, rsp_retry, rsp_data);
      end
      rst_n = 1'b1;
      idle("R1 first cycle after reset");

      for (int a = 0; a < 256; a++) wr(AW'(a), seed_val(AW'(a)), "R2 preload");
      idle("R4 idle lanes");

      // R2: four lanes on four banks
      rd(4'b1111, 8'h43, 8'h32, 8'h21, 8'h10, 4'b0000, 4'b0000, "R2 distinct banks");

      // R3 / R4 / R6: first collision on bank 0, loser 0x08 captured
      rd(4'b0011, 8'h00, 8'h00, 8'h08, 8'h04, 4'b0000, 4'b0010, "R3 R4 first conflict");
      idle("R6 capture gap");
      rd(4'b0011, 8'h00, 8'h00, 8'h08, 8'h04, 4'b0010, 4'b0000, "R5 R6 repeat served by side");

      // R5: neighbour bank 1 busy
      rd(4'b0111, 8'h00, 8'h05, 8'h08, 8'h04, 4'b0000, 4'b0010, "R5 neighbour busy");

      // R5 / R6: three lanes on bank 0, one side hit and one capture
      rd(4'b1101, 8'h08, 8'h0C, 8'h00, 8'h14, 4'b1000, 4'b0100, "R5 R6 three-way");
      idle("R6 capture gap");

      // R7: FIFO replacement
      rd(4'b0011, 8'h00, 8'h00, 8'h18, 8'h04, 4'b0000, 4'b0010, "R7 capture third line");
      idle("R7 gap");
      rd(4'b0011, 8'h00, 8'h00, 8'h08, 8'h04, 4'b0000, 4'b0010, "R7 oldest evicted");
      idle("R7 gap");
      rd(4'b0011, 8'h00, 8'h00, 8'h18, 8'h04, 4'b0010, 4'b0000, "R7 newer kept");

      // R5: two side hits on one bank, only the lowest served
      rd(4'b0111, 8'h00, 8'h18, 8'h08, 8'h04, 4'b0010, 4'b0100, "R5 one side per bank");

      // R8: write invalidates a held line
      wr(8'h18, 32'hDEAD_BEEF, "R8 write held line");
      rd(4'b0011, 8'h00, 8'h00, 8'h18, 8'h04, 4'b0000, 4'b0010, "R8 invalidated");
      idle("R8 gap");
      rd(4'b0011, 8'h00, 8'h00, 8'h18, 8'h04, 4'b0010, 4'b0000, "R8 refilled fresh data");

      // R8: write during a pending capture drops it
      rd(4'b0011, 8'h00, 8'h00, 8'h1C, 8'h04, 4'b0000, 4'b0010, "R8 conflict before write");
      wr(8'h1C, 32'h1234_5678, "R8 write pending line");
      rd(4'b0011, 8'h00, 8'h00, 8'h1C, 8'h04, 4'b0000, 4'b0010, "R8 capture dropped");
      idle("R8 gap");
      rd(4'b0011, 8'h00, 8'h00, 8'h1C, 8'h04, 4'b0010, 4'b0000, "R8 new capture served");

      // R2: read and write of the same line in one cycle
      drive(4'b0001, {8'h00, 8'h00, 8'h00, 8'h20}, 4'b0000, 4'b0000, 1'b1, 8'h20, 32'hCAFE_F00D,
            "R2 read during write old data");
      rd(4'b0001, 8'h00, 8'h00, 8'h00, 8'h20, 4'b0000, 4'b0000, "R2 read after write");

      // R5: last bank borrows bank 0
      rd(4'b0011, 8'h00, 8'h00, 8'h07, 8'h03, 4'b0000, 4'b0010, "R5 wrap conflict");
      idle("R6 gap");
      rd(4'b0011, 8'h00, 8'h00, 8'h07, 8'h03, 4'b0010, 4'b0000, "R5 wrap to bank 0");

      // R5: two banks in conflict at once
      rd(4'b1111, 8'h06, 8'h02, 8'h05, 8'h01, 4'b0000, 4'b1010, "R4 two conflicts");
      idle("R6 gap");
      rd(4'b1111, 8'h06, 8'h02, 8'h05, 8'h01, 4'b1000, 4'b0010, "R5 neighbour of bank 1 busy");

      // R3: winner is the lowest requesting lane, not lane 0
      rd(4'b1100, 8'h0D, 8'h09, 8'h00, 8'h00, 4'b0000, 4'b1000, "R3 lane 2 wins");
      // R3: equal addresses still collide
      rd(4'b0011, 8'h00, 8'h00, 8'h2A, 8'h2A, 4'b0000, 4'b0010, "R3 same line collides");

      idle("R4 drain");
      idle("R4 drain");
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule